// File: doc/BRIEF.md
# Masked GPIO Port with Edge Interrupts

A general purpose I/O port of `W` pins (32 by default) controlled through a small register bus. Each pin has its own direction bit. The driven value can be replaced in one access, or changed bit by bit through separate set and clear registers. A mask register shields chosen bits from every port write and hides them in the pin level readback. Pin inputs are resynchronised to the port clock before they are read or examined for edges.

Each pin can flag a rising edge, a falling edge, or either edge. Each kind of edge has its own sticky status bit, and writing ones to a status register acknowledges those bits. A single level interrupt output is high while any status bit is set.

The bus is a plain register interface: a write completes on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. No handshake is involved, so the port never applies back-pressure.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the direction, mask, output, enable and status registers are all zero, so `pin_oe`, `pin_out` and `irq` are low.
- R2: Register indices on `bus_addr`: 0 direction, 1 mask, 2 output value, 3 set, 4 clear, 5 pin level, 6 rise enable, 7 fall enable, 8 rise status, 9 fall status. `bus_be[k]` strobes bits 8k+7..8k. Lanes that are not strobed keep their contents. `bus_rdata` follows `bus_addr` in the same cycle. The direction, mask and enable registers read back what was written.
- R3: A write to index 2 replaces, in a single access, every unmasked bit in the strobed lanes.
- R4: A one written to index 3 drives that output high. Zero bits leave their outputs unchanged. Index 3 reads as zero.
- R5: A one written to index 4 drives that output low. Zero bits leave their outputs unchanged. Index 4 reads as zero.
- R6: A mask bit of one excludes that pin from writes to indices 2, 3 and 4, and makes it read as zero at index 5.
- R7: `pin_oe` equals the direction register (1 = output). `pin_out` equals the output register, which reads back in full at index 2.
- R8: Index 5 shows a `pin_in` change after the second rising clock edge, and not after the first.
- R9: A synchronised 0-to-1 transition on a pin whose rise enable bit is set sets its rise status bit. The bit is visible after the third clock edge following the input change.
- R10: A synchronised 1-to-0 transition on a pin whose fall enable bit is set sets its fall status bit, with the same latency as R9.
- R11: With both enables set, both kinds of transition are recorded. With neither set, no transition is recorded.
- R12: Writing ones to index 8 or 9 clears those status bits. Zero bits and unstrobed lanes are kept.
- R13: When an edge event and a clear of the same status bit fall in the same cycle, the bit ends set.
- R14: `irq` is high exactly when any rise or fall status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 4 | Register index |
| bus_be | input | W/8 | Byte lane strobes |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for `bus_addr` |
| pin_in | input | W | Asynchronous pin levels |
| pin_out | output | W | Driven pin values |
| pin_oe | output | W | Per-pin output enable |
| irq | output | 1 | Interrupt, OR of all status bits |

## Verification
Two things can meet in the same cycle: an acknowledge write to a status register and a freshly detected edge on the same pin. The bench changes a pin level, waits two clock edges so the synchroniser delivers the change, and then places a write-one-to-clear on the very edge where the status register would latch the event. The write clears a second, idle bit at the same time. The colliding bit must read back set and the idle bit cleared. A control run without the collision confirms that the clear works on its own.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RG_DIR   = 4'd0,
    RG_MASK  = 4'd1,
    RG_OUT   = 4'd2,
    RG_SET   = 4'd3,
    RG_CLR   = 4'd4,
    RG_PIN   = 4'd5,
    RG_REN   = 4'd6,
    RG_FEN   = 4'd7,
    RG_RSTAT = 4'd8,
    RG_FSTAT = 4'd9
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_out_ctl.sv
module gpio_out_ctl #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_mask,
  input  logic         wr_out,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] lane,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] out_q
);
  logic [W-1:0] touch;
  logic [W-1:0] out_nxt;

  assign touch = lane & ~mask_q;

  always_comb begin
    out_nxt = out_q;
    if (wr_out)      out_nxt = (out_q & ~touch) | (wdata & touch);
    else if (wr_set) out_nxt = out_q | (wdata & touch);
    else if (wr_clr) out_nxt = out_q & ~(wdata & touch);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mask_q <= '0;
      out_q  <= '0;
    end else begin
      if (wr_dir)  dir_q  <= (dir_q & ~lane) | (wdata & lane);
      if (wr_mask) mask_q <= (mask_q & ~lane) | (wdata & lane);
      out_q <= out_nxt;
    end
  end

  // R4
  set_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_q & $past(wdata & lane & ~mask_q)) == $past(wdata & lane & ~mask_q)));

  // R5
  clr_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((out_q & $past(wdata & lane & ~mask_q)) == '0));

  // R6
  mask_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_q ^ $past(out_q)) & $past(mask_q)) == '0);
endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  input  logic wr_ren,
  input  logic wr_fen,
  input  logic wr_rclr,
  input  logic wr_fclr,
  input  logic wd,
  output logic ren_q,
  output logic fen_q,
  output logic rstat_q,
  output logic fstat_q
);
  logic prev_q;
  logic rise_ev;
  logic fall_ev;

  assign rise_ev = smp & ~prev_q;
  assign fall_ev = ~smp & prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      ren_q   <= 1'b0;
      fen_q   <= 1'b0;
      rstat_q <= 1'b0;
      fstat_q <= 1'b0;
    end else begin
      prev_q <= smp;
      if (wr_ren) ren_q <= wd;
      if (wr_fen) fen_q <= wd;
      rstat_q <= (rstat_q & ~(wr_rclr & wd)) | (ren_q & rise_ev);
      fstat_q <= (fstat_q & ~(wr_fclr & wd)) | (fen_q & fall_ev);
    end
  end

  // R13
  rise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_q && rise_ev) |=> rstat_q);

  // R13
  fall_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fen_q && fall_ev) |=> fstat_q);

  // R12
  rise_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rclr && wd && !(ren_q && rise_ev)) |=> !rstat_q);

  // R9
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstat_q) |-> $past(ren_q && rise_ev));

  // R10
  fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fstat_q) |-> $past(fen_q && fall_ev));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [W/8-1:0]      bus_be,
  input  logic [W-1:0]        bus_wdata,
  output logic [W-1:0]        bus_rdata,
  input  logic [W-1:0]        pin_in,
  output logic [W-1:0]        pin_out,
  output logic [W-1:0]        pin_oe,
  output logic                irq
);
  localparam int unsigned NB = W / 8;

  logic [W-1:0] lane;
  logic [W-1:0] sync_q;
  logic [W-1:0] dir_q, mask_q, out_q;
  logic [W-1:0] ren_v, fen_v, rstat_v, fstat_v;
  logic         hit_dir, hit_mask, hit_out, hit_set, hit_clr;
  logic         hit_ren, hit_fen, hit_rst, hit_fst;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane[8*b +: 8] = {8{bus_be[b]}};
  end

  assign hit_dir  = bus_wr && (bus_addr == RG_DIR);
  assign hit_mask = bus_wr && (bus_addr == RG_MASK);
  assign hit_out  = bus_wr && (bus_addr == RG_OUT);
  assign hit_set  = bus_wr && (bus_addr == RG_SET);
  assign hit_clr  = bus_wr && (bus_addr == RG_CLR);
  assign hit_ren  = bus_wr && (bus_addr == RG_REN);
  assign hit_fen  = bus_wr && (bus_addr == RG_FEN);
  assign hit_rst  = bus_wr && (bus_addr == RG_RSTAT);
  assign hit_fst  = bus_wr && (bus_addr == RG_FSTAT);

  gpio_sync #(.W(W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (sync_q)
  );

  gpio_out_ctl #(.W(W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_dir  (hit_dir),
    .wr_mask (hit_mask),
    .wr_out  (hit_out),
    .wr_set  (hit_set),
    .wr_clr  (hit_clr),
    .lane    (lane),
    .wdata   (bus_wdata),
    .dir_q   (dir_q),
    .mask_q  (mask_q),
    .out_q   (out_q)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    gpio_edge_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp     (sync_q[i]),
      .wr_ren  (hit_ren & lane[i]),
      .wr_fen  (hit_fen & lane[i]),
      .wr_rclr (hit_rst & lane[i]),
      .wr_fclr (hit_fst & lane[i]),
      .wd      (bus_wdata[i]),
      .ren_q   (ren_v[i]),
      .fen_q   (fen_v[i]),
      .rstat_q (rstat_v[i]),
      .fstat_q (fstat_v[i])
    );
  end

  always_comb begin
    case (bus_addr)
      RG_DIR:   bus_rdata = dir_q;
      RG_MASK:  bus_rdata = mask_q;
      RG_OUT:   bus_rdata = out_q;
      RG_PIN:   bus_rdata = sync_q & ~mask_q;
      RG_REN:   bus_rdata = ren_v;
      RG_FEN:   bus_rdata = fen_v;
      RG_RSTAT: bus_rdata = rstat_v;
      RG_FSTAT: bus_rdata = fstat_v;
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(rstat_v | fstat_v);

  // R1
  irq_after_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !irq);

  // R7
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dir |=> (pin_oe & $past(lane)) == ($past(bus_wdata) & $past(lane)));
endmodule

// File: tb/tb_gpio_edge_port.sv
`timescale 1ns/1ps
module tb_gpio_edge_port;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [3:0]    bus_be = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  pin_in = '0;
  logic [W-1:0]  pin_out;
  logic [W-1:0]  pin_oe;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [W-1:0] m_dir = '0, m_mask = '0, m_out = '0;
  logic [W-1:0] m_ren = '0, m_fen = '0, m_rs = '0, m_fs = '0;
  logic [W-1:0] m_pin = '0;
  logic [W-1:0] ev_r, ev_f;

  always #4 clk = ~clk;

  gpio_edge_port #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [W-1:0] lanes(input logic [3:0] be);
    logic [W-1:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = {8{be[b]}};
    return r;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [W-1:0] d);
    logic [W-1:0] lm, keep;
    lm = lanes(be);
    keep = lm & ~m_mask;
    case (a)
      4'd0: m_dir  = (m_dir & ~lm) | (d & lm);
      4'd1: m_mask = (m_mask & ~lm) | (d & lm);
      4'd2: m_out  = (m_out & ~keep) | (d & keep);
      4'd3: m_out  = m_out | (d & keep);
      4'd4: m_out  = m_out & ~(d & keep);
      4'd6: m_ren  = (m_ren & ~lm) | (d & lm);
      4'd7: m_fen  = (m_fen & ~lm) | (d & lm);
      4'd8: m_rs   = m_rs & ~(d & lm);
      4'd9: m_fs   = m_fs & ~(d & lm);
      default: ;
    endcase
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic set_pin(input logic [W-1:0] v);
    ev_r = v & ~m_pin & m_ren;
    ev_f = ~v & m_pin & m_fen;
    m_rs = m_rs | ev_r;
    m_fs = m_fs | ev_f;
    m_pin = v;
    pin_in = v;
  endtask

  task automatic settle;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_stat(input string tag);
    logic [W-1:0] v;
    rd(4'd8, v); chk({tag, " rise status"}, v, m_rs);
    rd(4'd9, v); chk({tag, " fall status"}, v, m_fs);
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, |(m_rs | m_fs)});
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] v, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v); chk("R1 direction", v, '0);
    rd(4'd2, v); chk("R1 output", v, '0);
    rd(4'd8, v); chk("R1 rise status", v, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 R3 value writes under every strobe pattern
    for (int be = 0; be < 16; be++) begin
      d = (32'h1357_9BDF * (be + 1)) ^ 32'hA5C3_0F96;
      wr(4'd2, 4'(be), d);
      rd(4'd2, v); chk("R3 value write by lanes", v, m_out);
    end
    for (int be = 0; be < 16; be++) begin
      d = 32'h0F1E_2D3C ^ (32'h0101_0101 * be);
      wr(4'd0, 4'(be), d);
      rd(4'd0, v); chk("R2 direction by lanes", v, m_dir);
      // R7 pins follow registers
      chk("R7 pin_oe", pin_oe, m_dir);
      chk("R7 pin_out", pin_out, m_out);
    end
    rd(4'd3, v); chk("R4 set reads zero", v, '0);
    rd(4'd4, v); chk("R5 clear reads zero", v, '0);

    // R4 R5 set and clear sweeps
    for (int k = 0; k < 12; k++) begin
      d = 32'h9E37_79B9 * (k + 3);
      wr(4'd3, 4'((k * 5) % 16), d);
      rd(4'd2, v); chk("R4 set", v, m_out);
      wr(4'd4, 4'((k * 7 + 3) % 16), d ^ 32'h3C3C_C3C3);
      rd(4'd2, v); chk("R5 clear", v, m_out);
    end

    // R6 mask guards writes
    wr(4'd1, 4'hF, 32'hFF00_F0F0);
    rd(4'd1, v); chk("R2 mask readback", v, m_mask);
    wr(4'd2, 4'hF, 32'h1234_5678); rd(4'd2, v); chk("R6 masked value write", v, m_out);
    wr(4'd3, 4'hF, 32'hFFFF_FFFF); rd(4'd2, v); chk("R6 masked set", v, m_out);
    wr(4'd4, 4'hF, 32'hFFFF_FFFF); rd(4'd2, v); chk("R6 masked clear", v, m_out);

    // R8 pin latency, R6 masked pin read
    @(negedge clk);
    set_pin(32'hDEAD_BEEF);
    @(posedge clk); @(negedge clk);
    rd(4'd5, v); chk("R8 pin after one edge", v, '0);
    @(posedge clk); @(negedge clk);
    rd(4'd5, v); chk("R8 R6 pin after two edges", v, 32'hDEAD_BEEF & ~m_mask);
    set_pin('0);
    settle();
    wr(4'd1, 4'hF, '0);

    // R9 R10 R11 edge sweeps across all enable combinations
    wr(4'd6, 4'hF, 32'h3333_3333);
    wr(4'd7, 4'hF, 32'h5555_5555);
    rd(4'd6, v); chk("R2 rise enable readback", v, m_ren);
    for (int p = 0; p < 8; p++) begin
      d = (32'h1F35_6A79 << p) ^ (32'hC0DE_0000 >> p);
      set_pin(d); settle(); chk_stat("R9 R11 rising sweep");
      wr(4'd8, 4'hF, '1); wr(4'd9, 4'hF, '1); chk_stat("R12 full clear");
      set_pin('0); settle(); chk_stat("R10 R11 falling sweep");
      wr(4'd8, 4'hF, '1); wr(4'd9, 4'hF, '1);
    end

    // R12 partial acknowledge with zeros and strobes
    set_pin('1); settle();
    set_pin('0); settle();
    chk_stat("R11 both edges pending");
    wr(4'd8, 4'b0101, 32'h0F0F_0F0F); chk_stat("R12 partial rise clear");
    wr(4'd9, 4'b1010, 32'hFFFF_00FF); chk_stat("R12 partial fall clear");
    wr(4'd8, 4'hF, '1); wr(4'd9, 4'hF, '1);
    chk_stat("R14 irq low when idle");

    // R13 collision: pin 0 rises on the acknowledge edge, pin 1 does not
    set_pin(32'h3); settle();
    set_pin(32'h2); settle();
    chk_stat("R13 setup");
    @(negedge clk);
    set_pin(32'h3);
    repeat (2) @(posedge clk);
    wr(4'd8, 4'hF, 32'h3);
    m_rs = m_rs | ev_r;
    chk_stat("R13 event beats clear");
    rd(4'd8, v); chk("R13 pin0 kept, pin1 cleared", v & 32'h3, 32'h1);
    wr(4'd8, 4'hF, 32'h1); chk_stat("R12 clear without collision");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule